// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the host-facing register file of a multi-channel DMA controller. A host reaches it through an 8-bit I/O port bus. The bus has a 4-bit port address, a write data byte, a read data byte, and one-cycle write and read strobes. Each channel keeps the following state:
- a mask bit;
- a 3-bit mode field that holds the transfer direction and the operating mode;
- a 16-bit start address and a 16-bit running address;
- a 16-bit start count and a 16-bit running count;
- an 8-bit page value that sits beside the address counter.

The 16-bit registers are reached one byte at a time through a single port each. One shared byte-pointer flip-flop decides whether the low byte or the high byte is accessed. A dedicated port command resets that pointer to the low byte.

The transfer sequencer reads each channel's armed flag, addresses, counts, page and mode from the outputs. It advances the running address and running count with one-cycle step strobes. A channel becomes armed only when the host clears its mask, which is normally done after all of its settings are loaded. The count the host writes is the transfer length minus one.

Port map (4-bit `io_addr`):

| Port | Function |
|------|----------|
| 0–7 | Address or count of a channel. Bits [2:1] are the channel; bit 0 is 0 for address and 1 for count. |
| 8 | Mode write |
| 9 | Single-mask command |
| 10 | Clear byte pointer |
| 11 | Unused |
| 12–15 | Page register of channel `io_addr[1:0]` |

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every channel is masked (`armed` = 0) and the byte pointer selects the low byte. Every address, count, page and mode value is zero.
- R2: A write to an address port (`io_addr` = {0, ch, 0}) loads one byte of that channel's start address and running address. The byte is the low byte [7:0] when the pointer is clear and the high byte [15:8] when it is set. The pointer then toggles.
- R3: A write to a count port (`io_addr` = {0, ch, 1}) loads the start count and running count in the same byte order. The pointer then toggles.
- R4: Any write to port 10 clears the byte pointer, so the next address or count access uses the low byte.
- R5: A read of an address or count port returns one byte of the running copy, selected by the shared pointer, and then toggles the pointer. Reads of ports 8 to 11 return 0.
- R6: A write to port 8 stores `wr_data[4:2]` as the mode of channel `wr_data[1:0]`. In the stored field, bit 0 is the direction (1 = memory to I/O, 0 = I/O to memory) and bits [2:1] are the operating mode (0 single, 1 block, 2 demand, 3 cascade). No other channel's mode changes.
- R7: A write to port 9 sets the mask of channel `wr_data[1:0]` when `wr_data[2]` = 1 and clears it when `wr_data[2]` = 0. `armed[ch]` is the inverse of that channel's mask.
- R8: A write to port 12+ch loads that channel's 8-bit page. The page never changes otherwise, including when the running address wraps from FFFF to 0000.
- R9: `seq_addr_step` adds one to the running address of channel `seq_ch`, wrapping within 16 bits. The start address does not change.
- R10: `seq_cnt_step` subtracts one from the running count of channel `seq_ch`, wrapping from 0000 to FFFF. The start count does not change.
- R11: If a step strobe arrives in the same cycle as a host write to the same register of the same channel, the step is discarded and only the host byte is applied.
- R12: A write to port 11 changes no register and does not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Host port address |
| wr_data | input | 8 | Host write byte |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Read byte for `io_addr`, combinational |
| seq_ch | input | 2 | Channel the sequencer is stepping |
| seq_addr_step | input | 1 | Increment that channel's running address |
| seq_cnt_step | input | 1 | Decrement that channel's running count |
| armed | output | NCH | Per-channel unmasked flag |
| cur_addr | output | 16*NCH | Running addresses, channel 0 in the low bits |
| base_addr | output | 16*NCH | Start addresses |
| cur_cnt | output | 16*NCH | Running counts |
| base_cnt | output | 16*NCH | Start counts |
| page | output | 8*NCH | Page registers |
| mode | output | 3*NCH | {operating mode, direction} per channel |

## Verification
The directed cases cover three byte-order situations.
- Address, count and page bytes are sent in the natural low-then-high order.
- A byte is deliberately left over, which shows whether the clear-pointer command really resets the pointer.
- Writes and reads are interleaved, which shows whether both share one pointer.

Separate cases cover stepping across FFFF and below 0000. These separate the address wrap from the page value, and the running copies from the start copies. A coincident host write and step shows which one wins.

Random sequences then mix writes, reads, mask and mode commands, pointer clears, unused-port writes and steps on every channel. After every operation, all outputs are compared with a bench model. This catches wrong channel decoding and writes that leak between channels.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       io_addr,
  input  logic [7:0]       wr_data,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic [1:0]       seq_ch,
  input  logic             seq_addr_step,
  input  logic             seq_cnt_step,
  output logic [NCH-1:0]   armed,
  output logic [16*NCH-1:0] cur_addr,
  output logic [16*NCH-1:0] base_addr,
  output logic [16*NCH-1:0] cur_cnt,
  output logic [16*NCH-1:0] base_cnt,
  output logic [8*NCH-1:0] page,
  output logic [3*NCH-1:0] mode
);
  localparam logic [3:0] P_MODE = 4'd8;
  localparam logic [3:0] P_MASK = 4'd9;
  localparam logic [3:0] P_CLRP = 4'd10;

  logic [15:0] ca [NCH];
  logic [15:0] ba [NCH];
  logic [15:0] cc [NCH];
  logic [15:0] bc [NCH];
  logic [7:0]  pg [NCH];
  logic [2:0]  md [NCH];
  logic [NCH-1:0] msk;
  logic ptr;

  wire       is_ac  = ~io_addr[3];
  wire [1:0] ach    = io_addr[2:1];
  wire       is_cnt = io_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= 1'b0;
      msk <= '1;
      for (int i = 0; i < NCH; i++) begin
        ca[i] <= '0; ba[i] <= '0; cc[i] <= '0; bc[i] <= '0;
        pg[i] <= '0; md[i] <= '0;
      end
    end else begin
      if ((wr_en || rd_en) && is_ac) ptr <= ~ptr;
      if (wr_en && io_addr == P_CLRP) ptr <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        if (seq_addr_step && seq_ch == 2'(i) &&
            !(wr_en && is_ac && ach == 2'(i) && !is_cnt))
          ca[i] <= ca[i] + 16'd1;
        if (seq_cnt_step && seq_ch == 2'(i) &&
            !(wr_en && is_ac && ach == 2'(i) && is_cnt))
          cc[i] <= cc[i] - 16'd1;
        if (wr_en && is_ac && ach == 2'(i)) begin
          if (!is_cnt) begin
            if (ptr) begin ca[i][15:8] <= wr_data; ba[i][15:8] <= wr_data; end
            else     begin ca[i][7:0]  <= wr_data; ba[i][7:0]  <= wr_data; end
          end else begin
            if (ptr) begin cc[i][15:8] <= wr_data; bc[i][15:8] <= wr_data; end
            else     begin cc[i][7:0]  <= wr_data; bc[i][7:0]  <= wr_data; end
          end
        end
        if (wr_en && io_addr == P_MODE && wr_data[1:0] == 2'(i)) md[i] <= wr_data[4:2];
        if (wr_en && io_addr == P_MASK && wr_data[1:0] == 2'(i)) msk[i] <= wr_data[2];
        if (wr_en && io_addr == {2'b11, 2'(i)}) pg[i] <= wr_data;
      end
    end
  end

  logic [15:0] rsel;
  always_comb begin
    rsel = is_cnt ? cc[ach] : ca[ach];
    rd_data = '0;
    if (is_ac) rd_data = ptr ? rsel[15:8] : rsel[7:0];
    else if (io_addr[3:2] == 2'b11) rd_data = pg[io_addr[1:0]];
  end

  assign armed = ~msk;

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign cur_addr[16*g +: 16]  = ca[g];
    assign base_addr[16*g +: 16] = ba[g];
    assign cur_cnt[16*g +: 16]   = cc[g];
    assign base_cnt[16*g +: 16]  = bc[g];
    assign page[8*g +: 8]        = pg[g];
    assign mode[3*g +: 3]        = md[g];
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       io_addr,
  input logic [7:0]       wr_data,
  input logic             wr_en,
  input logic [1:0]       seq_ch,
  input logic             seq_addr_step,
  input logic             seq_cnt_step,
  input logic [NCH-1:0]   armed,
  input logic [16*NCH-1:0] cur_addr,
  input logic [16*NCH-1:0] base_addr,
  input logic [16*NCH-1:0] cur_cnt,
  input logic [16*NCH-1:0] base_cnt,
  input logic [8*NCH-1:0] page,
  input logic [3*NCH-1:0] mode
);
  // R1
  reset_mask_chk: assert property (@(posedge clk) !rst_n |=> armed == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_addr_step && seq_ch == 2'(g) && !(wr_en && io_addr == 4'(2*g))
      |=> cur_addr[16*g +: 16] == $past(cur_addr[16*g +: 16]) + 16'd1
          && $stable(base_addr[16*g +: 16]));
    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_cnt_step && seq_ch == 2'(g) && !(wr_en && io_addr == 4'(2*g+1))
      |=> cur_cnt[16*g +: 16] == $past(cur_cnt[16*g +: 16]) - 16'd1
          && $stable(base_cnt[16*g +: 16]));
    // R8
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && io_addr == 4'(12+g)) |=> $stable(page[8*g +: 8]));
    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && io_addr == 4'd8 && wr_data[1:0] == 2'(g)) |=> $stable(mode[3*g +: 3]));
    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && io_addr == 4'd9 && wr_data[1:0] == 2'(g) && wr_data[2] |=> !armed[g]);
    // R7
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && io_addr == 4'd9 && wr_data[1:0] == 2'(g) && !wr_data[2] |=> armed[g]);
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .wr_data(wr_data), .wr_en(wr_en),
  .seq_ch(seq_ch), .seq_addr_step(seq_addr_step), .seq_cnt_step(seq_cnt_step),
  .armed(armed), .cur_addr(cur_addr), .base_addr(base_addr), .cur_cnt(cur_cnt),
  .base_cnt(base_cnt), .page(page), .mode(mode)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic [3:0] io_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] seq_ch = 0;
  logic seq_addr_step = 0, seq_cnt_step = 0;
  logic [NCH-1:0] armed;
  logic [16*NCH-1:0] cur_addr, base_addr, cur_cnt, base_cnt;
  logic [8*NCH-1:0] page;
  logic [3*NCH-1:0] mode;

  dma_chan_regs #(.NCH(NCH)) dut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [15:0] m_ca[NCH], m_ba[NCH], m_cc[NCH], m_bc[NCH];
  logic [7:0] m_pg[NCH];
  logic [2:0] m_md[NCH];
  logic [NCH-1:0] m_msk;
  logic m_ptr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] setb(input logic [15:0] v, input logic hi, input logic [7:0] d);
    return hi ? {d, v[7:0]} : {v[15:8], d};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic [15:0] v;
    if (!a[3]) begin
      v = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
      return m_ptr ? v[15:8] : v[7:0];
    end
    if (a[3:2] == 2'b11) return m_pg[a[1:0]];
    return 8'h00;
  endfunction

  task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
    if (!a[3]) begin
      if (a[0]) begin m_cc[a[2:1]] = setb(m_cc[a[2:1]], m_ptr, d); m_bc[a[2:1]] = setb(m_bc[a[2:1]], m_ptr, d); end
      else      begin m_ca[a[2:1]] = setb(m_ca[a[2:1]], m_ptr, d); m_ba[a[2:1]] = setb(m_ba[a[2:1]], m_ptr, d); end
      m_ptr = ~m_ptr;
    end else if (a == 4'd8) m_md[d[1:0]] = d[4:2];
    else if (a == 4'd9) m_msk[d[1:0]] = d[2];
    else if (a == 4'd10) m_ptr = 0;
    else if (a[3:2] == 2'b11) m_pg[a[1:0]] = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic rd(input string req, input logic [3:0] a);
    @(negedge clk); io_addr = a; rd_en = 1;
    #1 chk(req, {24'h0, rd_data}, {24'h0, exp_rd(a)});
    @(negedge clk); rd_en = 0;
    if (!a[3]) m_ptr = ~m_ptr;
  endtask

  task automatic step(input logic [1:0] ch, input bit sa, input bit sc);
    @(negedge clk); seq_ch = ch; seq_addr_step = sa; seq_cnt_step = sc;
    @(negedge clk); seq_addr_step = 0; seq_cnt_step = 0;
    if (sa) m_ca[ch] = m_ca[ch] + 16'd1;
    if (sc) m_cc[ch] = m_cc[ch] - 16'd1;
  endtask

  task automatic cmp_all(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk(req, {16'h0, cur_addr[16*c +: 16]}, {16'h0, m_ca[c]});
      chk(req, {16'h0, base_addr[16*c +: 16]}, {16'h0, m_ba[c]});
      chk(req, {16'h0, cur_cnt[16*c +: 16]}, {16'h0, m_cc[c]});
      chk(req, {16'h0, base_cnt[16*c +: 16]}, {16'h0, m_bc[c]});
      chk(req, {24'h0, page[8*c +: 8]}, {24'h0, m_pg[c]});
      chk(req, {29'h0, mode[3*c +: 3]}, {29'h0, m_md[c]});
    end
    chk(req, {28'h0, armed}, {28'h0, ~m_msk});
  endtask

  initial begin
    #(8*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_ca[c] = 0; m_ba[c] = 0; m_cc[c] = 0; m_bc[c] = 0; m_pg[c] = 0; m_md[c] = 0;
    end
    m_msk = '1; m_ptr = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp_all("R1");
    rd("R1", 4'd0);
    rd("R1", 4'd0);
    // R2 address write low then high
    wr(4'd10, 0);
    wr(4'd2, 8'h34); wr(4'd2, 8'h12);
    chk("R2", {16'h0, cur_addr[31:16]}, 32'h1234);
    chk("R2", {16'h0, base_addr[31:16]}, 32'h1234);
    // R3 count write
    wr(4'd5, 8'hFF); wr(4'd5, 8'h01);
    chk("R3", {16'h0, cur_cnt[47:32]}, 32'h01FF);
    // R4 clear pointer with a byte left over
    wr(4'd0, 8'hAA); wr(4'd10, 8'h5A); wr(4'd0, 8'hBB);
    chk("R4", {16'h0, cur_addr[15:0]}, 32'h00BB);
    wr(4'd10, 0);
    // R5 reads share the pointer
    rd("R5", 4'd2); rd("R5", 4'd2);
    rd("R5", 4'd5); wr(4'd5, 8'h02);
    chk("R5", {16'h0, cur_cnt[47:32]}, 32'h02FF);
    wr(4'd10, 0);
    rd("R5", 4'd8);
    // R6 mode
    wr(4'd8, 8'h17);
    chk("R6", {29'h0, mode[11:9]}, 32'd5);
    cmp_all("R6");
    // R7 mask clear / set
    wr(4'd9, 8'h01);
    chk("R7", {28'h0, armed}, 32'h2);
    wr(4'd9, 8'h05);
    chk("R7", {28'h0, armed}, 32'h0);
    // R8 page independent of wrap
    wr(4'd13, 8'h12);
    wr(4'd2, 8'hFF); wr(4'd2, 8'hFF);
    step(2'd1, 1, 0);
    chk("R8", {24'h0, page[15:8]}, 32'h12);
    // R9 address wrap, start copy kept
    chk("R9", {16'h0, cur_addr[31:16]}, 32'h0000);
    chk("R9", {16'h0, base_addr[31:16]}, 32'hFFFF);
    // R10 count wrap from zero
    step(2'd0, 0, 1);
    chk("R10", {16'h0, cur_cnt[15:0]}, 32'hFFFF);
    chk("R10", {16'h0, base_cnt[15:0]}, 32'h0000);
    // R11 coincident write and step
    @(negedge clk); io_addr = 4'd2; wr_data = 8'h40; wr_en = 1; seq_ch = 1; seq_addr_step = 1;
    @(negedge clk); wr_en = 0; seq_addr_step = 0;
    model_wr(4'd2, 8'h40);
    chk("R11", {16'h0, cur_addr[31:16]}, 32'h0040);
    cmp_all("R11");
    // R12 unused port
    wr(4'd11, 8'hFF);
    cmp_all("R12");
    rd("R12", 4'd0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 7);
      case (op)
        0, 1: wr(4'($urandom_range(0, 7)), 8'($urandom));
        2: rd("R5", 4'($urandom_range(0, 15)));
        3: wr(4'd8, 8'($urandom));
        4: wr(4'd9, 8'($urandom));
        5: wr(4'($urandom_range(10, 15)), 8'($urandom));
        default: step(2'($urandom), 1'($urandom), 1'($urandom));
      endcase
      cmp_all("R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule